// File: doc/BRIEF.md
# Unrolled 16-Bit Substitution-Permutation Cipher

This block turns one 16-bit data word into a 16-bit ciphertext under a 64-bit subkey, with the whole datapath laid out as combinational logic between the input ports and a single output register. A new block can be presented on every clock. The ciphertext appears on the output one edge after the load strobe is sampled high. While the strobe is low, the register keeps its last result.

The subkey is cut into four 16-bit round keys. Four regular rounds each mix in one of these keys, pass the word through four different 4-bit S-boxes side by side, and then spread the bits with a rotate-and-XOR linear map. A closing round has no linear map. It mixes in a derived pre-key, applies the S-box layer, and then XORs a derived post-key into the result. The block is meant to sit inside a larger lightweight cipher engine, which supplies the subkeys and chains the blocks.

Top module: `spn16_unrolled`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `blk_o` to 0x0000 and takes priority over `ld_en`.
- R2: While `ld_en` is low and `rst` is low, `blk_o` keeps its value, whatever `blk_i` and `key_i` do.
- R3: When `ld_en` is high at a rising edge, `blk_o` shows after that edge the cipher of the `blk_i` and `key_i` values present at that edge.
- R4: Round keys come from the subkey in a fixed order: K1 = `key_i[63:48]`, K2 = `key_i[47:32]`, K3 = `key_i[31:16]`, K4 = `key_i[15:0]`. Regular round n uses Kn.
- R5: Each regular round computes L(S(x XOR Kn)), with the input of round 1 being `blk_i`.
- R6: The S-box layer maps nibble [15:12] through S1, [11:8] through S2, [7:4] through S3 and [3:0] through S4. The tables, listed for inputs 0 to F, are: S1 = 6 5 C A 1 E 7 9 B 0 3 D 8 F 4 2; S2 = 7 C E 9 2 1 5 F B 6 D 0 4 8 A 3; S3 = 4 A 1 6 8 F 7 C 3 0 E D 5 9 B 2; S4 = F 4 5 8 9 7 2 1 A 3 0 E 6 C D B.
- R7: The linear map is L(x) = x XOR rotl(x,6) XOR rotl(x,10) on 16 bits. As a result, it keeps the parity of its input.
- R8: The closing round computes S(x XOR K5) XOR K6, where K5 = K1 XOR K3 and K6 = K2 XOR K4. It has no linear map.
- R9: Loads on consecutive clocks each produce their own correct ciphertext on consecutive cycles, so there is no stall between blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load strobe; captures a new ciphertext when high |
| blk_i | input | 16 | Plaintext block |
| key_i | input | 64 | Subkey holding the four round keys |
| blk_o | output | 16 | Registered ciphertext |

## Verification
The bench builds the block with its default parameters: a 16-bit block, a 64-bit subkey, four regular rounds and rotation amounts of 6 and 10. Only with these values does the key split produce the K1 to K4 ordering and the K5/K6 derivation that the bit-level reference model in the bench assumes. Directed vectors put a non-zero value into only one round-key slot at a time, so each slot's role in the regular rounds and in the derived keys shows up in the output. A long run of back-to-back random loads, a reset that collides with a load, and idle stretches with changing inputs cover the register behaviour.

// File: rtl/spn16_pkg.sv
package spn16_pkg;

   localparam int NIB_W   = 4;
   localparam int NUM_BOX = 4;

   // Four distinct 4x4 substitution tables, box 0 serves the top nibble.
   function automatic logic [3:0] sbox_lookup(input int box, input logic [3:0] v);
      logic [3:0] r;
      r = 4'h0;
      case (box)
         0: case (v)
               4'h0: r = 4'h6;  4'h1: r = 4'h5;  4'h2: r = 4'hC;  4'h3: r = 4'hA;
               4'h4: r = 4'h1;  4'h5: r = 4'hE;  4'h6: r = 4'h7;  4'h7: r = 4'h9;
               4'h8: r = 4'hB;  4'h9: r = 4'h0;  4'hA: r = 4'h3;  4'hB: r = 4'hD;
               4'hC: r = 4'h8;  4'hD: r = 4'hF;  4'hE: r = 4'h4;  default: r = 4'h2;
            endcase
         1: case (v)
               4'h0: r = 4'h7;  4'h1: r = 4'hC;  4'h2: r = 4'hE;  4'h3: r = 4'h9;
               4'h4: r = 4'h2;  4'h5: r = 4'h1;  4'h6: r = 4'h5;  4'h7: r = 4'hF;
               4'h8: r = 4'hB;  4'h9: r = 4'h6;  4'hA: r = 4'hD;  4'hB: r = 4'h0;
               4'hC: r = 4'h4;  4'hD: r = 4'h8;  4'hE: r = 4'hA;  default: r = 4'h3;
            endcase
         2: case (v)
               4'h0: r = 4'h4;  4'h1: r = 4'hA;  4'h2: r = 4'h1;  4'h3: r = 4'h6;
               4'h4: r = 4'h8;  4'h5: r = 4'hF;  4'h6: r = 4'h7;  4'h7: r = 4'hC;
               4'h8: r = 4'h3;  4'h9: r = 4'h0;  4'hA: r = 4'hE;  4'hB: r = 4'hD;
               4'hC: r = 4'h5;  4'hD: r = 4'h9;  4'hE: r = 4'hB;  default: r = 4'h2;
            endcase
         default: case (v)
               4'h0: r = 4'hF;  4'h1: r = 4'h4;  4'h2: r = 4'h5;  4'h3: r = 4'h8;
               4'h4: r = 4'h9;  4'h5: r = 4'h7;  4'h6: r = 4'h2;  4'h7: r = 4'h1;
               4'h8: r = 4'hA;  4'h9: r = 4'h3;  4'hA: r = 4'h0;  4'hB: r = 4'hE;
               4'hC: r = 4'h6;  4'hD: r = 4'hC;  4'hE: r = 4'hD;  default: r = 4'hB;
            endcase
      endcase
      return r;
   endfunction

   // Elaboration-time check that a table is a permutation of 0..15.
   function automatic bit sbox_is_bijective(input int box);
      logic [15:0] seen;
      seen = '0;
      for (int v = 0; v < 16; v++) begin
         seen[sbox_lookup(box, 4'(v))] = 1'b1;
      end
      return &seen;
   endfunction

endpackage

// File: rtl/spn16_key_split.sv
module spn16_key_split #(
   parameter int BLK_W = 16,
   parameter int KEY_W = 64,
   parameter int N_RND = 4
) (
   input  logic [KEY_W-1:0]            key_i,
   output logic [N_RND-1:0][BLK_W-1:0] rk_o,
   output logic [BLK_W-1:0]            pre_o,
   output logic [BLK_W-1:0]            post_o
);

   if (KEY_W != N_RND * BLK_W) begin : g_bad_key
      $error("spn16_key_split: KEY_W must equal N_RND*BLK_W");
   end
   if ((N_RND % 2) != 0) begin : g_bad_rnd
      $error("spn16_key_split: N_RND must be even");
   end

   // First round key sits in the most significant slice.
   for (genvar r = 0; r < N_RND; r++) begin : g_slice
      assign rk_o[r] = key_i[KEY_W-1-r*BLK_W -: BLK_W];
   end

   // Pre-key folds the odd-numbered round keys, post-key the even-numbered.
   always_comb begin
      pre_o  = '0;
      post_o = '0;
      for (int r = 0; r < N_RND; r++) begin
         if ((r % 2) == 0) pre_o  = pre_o  ^ rk_o[r];
         else              post_o = post_o ^ rk_o[r];
      end
   end

endmodule

// File: rtl/spn16_sub_layer.sv
module spn16_sub_layer
   import spn16_pkg::*;
#(
   parameter int BLK_W = 16
) (
   input  logic [BLK_W-1:0] x_i,
   output logic [BLK_W-1:0] y_o
);

   localparam int N_NIB = BLK_W / NIB_W;

   if (BLK_W != NIB_W * NUM_BOX) begin : g_bad_w
      $error("spn16_sub_layer: BLK_W must be one nibble per S-box");
   end

   for (genvar n = 0; n < N_NIB; n++) begin : g_nib
      localparam int LO = BLK_W - NIB_W * (n + 1);
      if (!sbox_is_bijective(n)) begin : g_not_perm
         $error("spn16_sub_layer: S-box table is not a permutation");
      end
      assign y_o[LO +: NIB_W] = sbox_lookup(n, x_i[LO +: NIB_W]);
   end

endmodule

// File: rtl/spn16_lin_layer.sv
module spn16_lin_layer #(
   parameter int BLK_W = 16,
   parameter int ROT_A = 6,
   parameter int ROT_B = 10
) (
   input  logic [BLK_W-1:0] x_i,
   output logic [BLK_W-1:0] y_o
);

   if (ROT_A <= 0 || ROT_A >= BLK_W || ROT_B <= 0 || ROT_B >= BLK_W) begin : g_bad_rot
      $error("spn16_lin_layer: rotation amounts must lie in 1..BLK_W-1");
   end
   if (ROT_A == ROT_B) begin : g_same_rot
      $error("spn16_lin_layer: rotation amounts must differ");
   end

   logic [BLK_W-1:0] rot_a;
   logic [BLK_W-1:0] rot_b;

   assign rot_a = {x_i[BLK_W-1-ROT_A:0], x_i[BLK_W-1:BLK_W-ROT_A]};
   assign rot_b = {x_i[BLK_W-1-ROT_B:0], x_i[BLK_W-1:BLK_W-ROT_B]};
   assign y_o   = x_i ^ rot_a ^ rot_b;

endmodule

// File: rtl/spn16_round.sv
module spn16_round #(
   parameter int BLK_W = 16,
   parameter int ROT_A = 6,
   parameter int ROT_B = 10,
   parameter bit FINAL = 1'b0
) (
   input  logic [BLK_W-1:0] x_i,
   input  logic [BLK_W-1:0] pre_key_i,
   input  logic [BLK_W-1:0] post_key_i,
   output logic [BLK_W-1:0] sub_o,
   output logic [BLK_W-1:0] y_o
);

   logic [BLK_W-1:0] mixed;

   assign mixed = x_i ^ pre_key_i;

   spn16_sub_layer #(.BLK_W(BLK_W)) u_sub (
      .x_i (mixed),
      .y_o (sub_o)
   );

   if (FINAL) begin : g_closing
      assign y_o = sub_o ^ post_key_i;
   end else begin : g_regular
      logic [BLK_W-1:0] lin_w;
      spn16_lin_layer #(.BLK_W(BLK_W), .ROT_A(ROT_A), .ROT_B(ROT_B)) u_lin (
         .x_i (sub_o),
         .y_o (lin_w)
      );
      assign y_o = lin_w ^ post_key_i;
   end

endmodule

// File: rtl/spn16_unrolled.sv
module spn16_unrolled #(
   parameter int BLK_W = 16,
   parameter int KEY_W = 64,
   parameter int N_RND = 4,
   parameter int ROT_A = 6,
   parameter int ROT_B = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic [BLK_W-1:0] blk_i,
   input  logic [KEY_W-1:0] key_i,
   output logic [BLK_W-1:0] blk_o
);

   localparam int N_STAGE = N_RND + 1;

   if (N_RND < 1) begin : g_bad_rnd
      $error("spn16_unrolled: at least one regular round is needed");
   end

   logic [N_RND-1:0][BLK_W-1:0] rk;
   logic [BLK_W-1:0]            k_pre;
   logic [BLK_W-1:0]            k_post;
   logic [BLK_W-1:0]            stage [0:N_STAGE];
   logic [BLK_W-1:0]            sub_w [0:N_STAGE-1];
   logic [BLK_W-1:0]            ct_q;

   spn16_key_split #(.BLK_W(BLK_W), .KEY_W(KEY_W), .N_RND(N_RND)) u_keys (
      .key_i  (key_i),
      .rk_o   (rk),
      .pre_o  (k_pre),
      .post_o (k_post)
   );

   assign stage[0] = blk_i;

   for (genvar r = 0; r < N_STAGE; r++) begin : g_rnd
      if (r < N_RND) begin : g_reg
         spn16_round #(.BLK_W(BLK_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .FINAL(1'b0)) u_round (
            .x_i        (stage[r]),
            .pre_key_i  (rk[r]),
            .post_key_i ({BLK_W{1'b0}}),
            .sub_o      (sub_w[r]),
            .y_o        (stage[r+1])
         );

         AST_LIN_PARITY: assert property (@(posedge clk) disable iff (rst)
            (^stage[r+1]) == (^sub_w[r]));  // R7
      end else begin : g_fin
         spn16_round #(.BLK_W(BLK_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .FINAL(1'b1)) u_round (
            .x_i        (stage[r]),
            .pre_key_i  (k_pre),
            .post_key_i (k_post),
            .sub_o      (sub_w[r]),
            .y_o        (stage[r+1])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        ct_q <= '0;
      else if (ld_en) ct_q <= stage[N_STAGE];
   end

   assign blk_o = ct_q;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (blk_o == '0));  // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !ld_en |=> $stable(blk_o));  // R2

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      ld_en |=> (blk_o == $past(stage[N_STAGE])));  // R3

endmodule

// File: tb/tb_spn16_unrolled.sv
module tb_spn16_unrolled;

   localparam int CLK_PERIOD = 10;

   // S-box tables packed with input 0 in the lowest nibble.
   localparam logic [63:0] T_S1 = 64'h24F8D30B97E1AC56;
   localparam logic [63:0] T_S2 = 64'h3A840D6BF5129EC7;
   localparam logic [63:0] T_S3 = 64'h2B95DE03C7F861A4;
   localparam logic [63:0] T_S4 = 64'hBDC6E03A1279854F;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [15:0] blk_i = '0;
   logic [63:0] key_i = '0;
   logic [15:0] blk_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic        loaded_q = 1'b0;
   logic [15:0] exp_q [$];
   logic [15:0] last_exp = '0;

   spn16_unrolled dut (
      .clk   (clk),
      .rst   (rst),
      .ld_en (ld_en),
      .blk_i (blk_i),
      .key_i (key_i),
      .blk_o (blk_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model ----------------
   function automatic logic [15:0] m_sub(input logic [15:0] x);
      logic [15:0] y;
      y[15:12] = T_S1[x[15:12]*4 +: 4];
      y[11:8]  = T_S2[x[11:8]*4 +: 4];
      y[7:4]   = T_S3[x[7:4]*4 +: 4];
      y[3:0]   = T_S4[x[3:0]*4 +: 4];
      return y;
   endfunction

   function automatic logic [15:0] m_rotl(input logic [15:0] x, input int s);
      return 16'((x << s) | (x >> (16 - s)));
   endfunction

   function automatic logic [15:0] m_lin(input logic [15:0] x);
      return x ^ m_rotl(x, 6) ^ m_rotl(x, 10);
   endfunction

   function automatic logic [15:0] m_enc(input logic [15:0] p, input logic [63:0] k);
      logic [15:0] kk [4];
      logic [15:0] x;
      kk[0] = k[63:48]; kk[1] = k[47:32]; kk[2] = k[31:16]; kk[3] = k[15:0];  // R4
      x = p;
      for (int r = 0; r < 4; r++) x = m_lin(m_sub(x ^ kk[r]));               // R5 R6 R7
      return m_sub(x ^ (kk[0] ^ kk[2])) ^ (kk[1] ^ kk[3]);                  // R8
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   always @(posedge clk) loaded_q <= ld_en & ~rst;

   // Monitor: every accepted load is compared one cycle later.
   always @(negedge clk) begin
      if (loaded_q) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3: got %h expected <none queued>", blk_o);
         end else begin
            check("R3/R4/R5/R6/R7/R8/R9 ciphertext", blk_o, exp_q.pop_front());
         end
      end
   end

   // Driver: present one block and queue its expected ciphertext.
   task automatic send(input logic [15:0] p, input logic [63:0] k);
      @(negedge clk);
      blk_i = p;
      key_i = k;
      ld_en = 1'b1;
      last_exp = m_enc(p, k);
      exp_q.push_back(last_exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ld_en = 1'b0;
         blk_i = 16'($urandom);
         key_i = {$urandom, $urandom};
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", blk_o, 16'h0000);
      rst = 1'b0;

      // Directed vectors, each key slot on its own.
      send(16'h0000, 64'h0);
      send(16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      send(16'h0001, 64'h1234_0000_0000_0000);                        // R4 K1
      send(16'h0001, 64'h0000_1234_0000_0000);                        // R4 K2 / R8 K6
      send(16'h0001, 64'h0000_0000_1234_0000);                        // R4 K3 / R8 K5
      send(16'h0001, 64'h0000_0000_0000_1234);                        // R4 K4
      send(16'h8000, 64'h0000_0000_0000_0000);                        // R6 top nibble
      send(16'hA5C3, 64'h0F0F_F0F0_3C3C_C3C3);

      // Hold: idle with changing inputs, output keeps the last result.
      idle(4);
      check("R2 hold while idle", blk_o, last_exp);

      // Back-to-back random loads.
      for (int i = 0; i < 60; i++) send(16'($urandom), {$urandom, $urandom});  // R9
      idle(3);
      check("R2 hold after burst", blk_o, last_exp);

      // Reset colliding with a load.
      send(16'h1357, 64'h2468_ACE0_1357_9BDF);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset beats load", blk_o, 16'h0000);
      rst = 1'b0;
      ld_en = 1'b0;
      idle(2);
      check("R2 hold after reset", blk_o, 16'h0000);

      send(16'hBEEF, 64'hDEAD_BEEF_0123_4567);
      idle(2);
      check("R3 load after reset", blk_o, last_exp);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule